// File: doc/BRIEF.md
# I2C Slave Receive Engine with Address and Data Hold

This block is the receive side of an I2C slave. It runs on the system clock and treats SCL and SDA as slow lines that it oversamples. It finds start and stop conditions on the bus and shifts in bytes MSB first. The first byte after any start or repeated start is always the address byte. The block accepts a 7-bit own address, a 10-bit own address sent as two bytes, or the general call address 0x00. Every byte after an accepted address is data. A byte is never taken as an address in that position, even if its value equals an address.

Software can ask the block to stop after the eighth bit of an address byte (address hold) or of a data byte (data hold). In that case the block holds SCL low and raises an interrupt pulse. Software can then inspect the byte and choose ACK or NACK through `ack_value_i`. A `release_i` strobe lets the bus run again. This behaviour does not depend on the value `ack_value_i` held when the byte began.

Each accepted byte goes out on a receive stream (`rx_data_o`, `rx_is_addr_o`, `rx_valid_o`, `rx_ready_i`). The stream has no back-pressure toward the bus. `rx_valid_o` stays high until a cycle with `rx_valid_o && rx_ready_i`. A later byte that arrives before that read overwrites the payload and keeps `rx_valid_o` high. The receive-buffer-full status is `rx_valid_o` itself.

Top module: `i2c_hold_slave`

## Requirements
- R1: `start_o` sets when SDA falls while SCL is high, and clears on a stop. `stop_o` sets when SDA rises while SCL is high, and clears on a start. Both are 0 after reset. No control input changes either one.
- R2: In 7-bit mode the first byte after a start is accepted when bits 7..1 equal `own_addr_i[6:0]` and bit 0 (direction) is 0.
- R3: During the ninth clock of an accepted byte the block drives SDA low when `ack_value_i` is 0 (ACK) and leaves SDA released when it is 1 (NACK). The value is taken when the ACK phase begins: at the eighth SCL fall without hold, or at `release_i` during a hold. After a NACK the block ignores the bus until the next start.
- R4: A first byte that does not match gets no ACK, no stream output and no interrupt. Every later byte up to the next start or repeated start is ignored, even a byte equal to the own address byte.
- R5: Once an address is accepted, every following byte is data (`rx_is_addr_o` = 0), whatever its value.
- R6: With `addr_hold_en_i` set, the block holds SCL low after the eighth SCL fall of every accepted address byte. It also pulses `irq_o` for one cycle. Both happen for either value of `ack_value_i`. SCL stays low until `release_i`.
- R7: With `data_hold_en_i` set, accepted data bytes get the same stretch and interrupt after their eighth clock, for either value of `ack_value_i`.
- R8: `ack_time_o` is high from the eighth SCL fall to the ninth SCL fall of each accepted byte, only while `addr_hold_en_i` or `data_hold_en_i` is set. It is never high otherwise.
- R9: In 10-bit mode the first byte must be binary 11110, then `own_addr_i[9:8]`, then direction 0. The second byte must equal `own_addr_i[7:0]`. With address hold, both bytes are stretched and both show `ack_time_o`. A wrong second byte gets a NACK.
- R10: With `gcall_en_i` set, first byte 0x00 is accepted and gets address-hold treatment. With `gcall_en_i` clear, 0x00 is ignored.
- R11: `rx_valid_o` rises at the eighth SCL rise of an accepted byte, with `rx_data_o` and `rx_is_addr_o`. It stays high until `rx_valid_o && rx_ready_i`.
- R12: Without a hold for that byte, `irq_o` pulses for one cycle after the ninth SCL fall of an accepted byte.
- R13: The block changes its SDA drive only while SCL is low. SCL is driven low only during a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_drive_low_o | output | 1 | Open-drain pull-down for SCL (clock stretch) |
| sda_drive_low_o | output | 1 | Open-drain pull-down for SDA (ACK) |
| addr_hold_en_i | input | 1 | Stretch after eighth bit of address bytes |
| data_hold_en_i | input | 1 | Stretch after eighth bit of data bytes |
| gcall_en_i | input | 1 | Accept general call address 0x00 |
| ten_bit_en_i | input | 1 | 10-bit own address mode |
| own_addr_i | input | 10 | Own address (7-bit mode uses bits 6..0) |
| ack_value_i | input | 1 | 0 = ACK, 1 = NACK |
| release_i | input | 1 | One-cycle strobe that ends a clock stretch |
| rx_data_o | output | 8 | Received byte |
| rx_is_addr_o | output | 1 | Received byte was an address byte |
| rx_valid_o | output | 1 | Receive buffer full |
| rx_ready_i | input | 1 | Consumer takes the byte |
| ack_time_o | output | 1 | Acknowledge window status |
| start_o | output | 1 | Start seen since last stop |
| stop_o | output | 1 | Stop seen since last start |
| irq_o | output | 1 | One-cycle slave interrupt pulse |

## Verification
Suppose the byte-position state is wrong, for example a data byte is taken as an address. The ACK level on SDA in the ninth clock of that same byte is then wrong, and `rx_is_addr_o` is wrong at the eighth rise. A bad hold decision shows up within a few clocks of the eighth SCL fall, as a missing stretch, a missing `irq_o` or a missing `ack_time_o`. A bad bit count shifts every later ACK by one bit. An unmatched address that was not properly dropped shows up as an ACK on a byte that should be ignored.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_BITS = 8;
  localparam int ADDR_BITS = 10;
  localparam int CNT_W     = $clog2(BYTE_BITS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_BYTE_END,
    ST_HOLD,
    ST_ACK
  } i2cs_state_e;

  typedef enum logic [1:0] {
    K_FIRST,
    K_LOWER,
    K_DATA
  } i2cs_kind_e;
endpackage

// File: rtl/i2cs_line_cond.sv
module i2cs_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q, scl_s;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s = scl_pipe[LAST];
  assign sda_s = sda_pipe[LAST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match
  import i2cs_pkg::*;
(
  input  logic [BYTE_BITS-1:0] byte_i,
  input  i2cs_kind_e           kind_i,
  input  logic                 ten_bit_en_i,
  input  logic                 gcall_en_i,
  input  logic [ADDR_BITS-1:0] own_addr_i,
  output logic                 accept_o,
  output logic                 upper_o
);
  logic gc_hit, seven_hit, ten_hit;

  assign gc_hit    = gcall_en_i && (byte_i == '0);
  assign seven_hit = !ten_bit_en_i && (byte_i[7:1] == own_addr_i[6:0]) && !byte_i[0];
  assign ten_hit   = ten_bit_en_i && (byte_i[7:3] == 5'b11110) &&
                     (byte_i[2:1] == own_addr_i[9:8]) && !byte_i[0];

  always_comb begin
    accept_o = 1'b0;
    upper_o  = 1'b0;
    unique case (kind_i)
      K_FIRST: begin
        accept_o = gc_hit || seven_hit || ten_hit;
        upper_o  = ten_hit && !gc_hit;
      end
      K_LOWER: accept_o = (byte_i == own_addr_i[7:0]);
      K_DATA:  accept_o = 1'b1;
      default: accept_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2c_hold_slave.sv
module i2c_hold_slave
  import i2cs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 scl_drive_low_o,
  output logic                 sda_drive_low_o,
  input  logic                 addr_hold_en_i,
  input  logic                 data_hold_en_i,
  input  logic                 gcall_en_i,
  input  logic                 ten_bit_en_i,
  input  logic [ADDR_BITS-1:0] own_addr_i,
  input  logic                 ack_value_i,
  input  logic                 release_i,
  output logic [BYTE_BITS-1:0] rx_data_o,
  output logic                 rx_is_addr_o,
  output logic                 rx_valid_o,
  input  logic                 rx_ready_i,
  output logic                 ack_time_o,
  output logic                 start_o,
  output logic                 stop_o,
  output logic                 irq_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS - 1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic m_accept, m_upper, hold_sel;
  logic [BYTE_BITS-1:0] byte_in;

  i2cs_state_e          state;
  i2cs_kind_e           kind, next_kind;
  logic [CNT_W-1:0]     bit_cnt;
  logic [BYTE_BITS-1:0] shreg;
  logic                 held_q, nack_q, sda_drv;

  i2cs_line_cond #(.SYNC_STAGES(SYNC_STAGES)) cond_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_in = {shreg[BYTE_BITS-2:0], sda_s};

  i2cs_addr_match match_i (
    .byte_i(byte_in), .kind_i(kind), .ten_bit_en_i(ten_bit_en_i),
    .gcall_en_i(gcall_en_i), .own_addr_i(own_addr_i),
    .accept_o(m_accept), .upper_o(m_upper)
  );

  // hold choice depends on which kind of byte has just completed
  assign hold_sel = (kind == K_DATA) ? data_hold_en_i : addr_hold_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      kind         <= K_FIRST;
      next_kind    <= K_FIRST;
      bit_cnt      <= '0;
      shreg        <= '0;
      held_q       <= 1'b0;
      nack_q       <= 1'b0;
      sda_drv      <= 1'b0;
      rx_data_o    <= '0;
      rx_is_addr_o <= 1'b0;
      rx_valid_o   <= 1'b0;
      start_o      <= 1'b0;
      stop_o       <= 1'b0;
      irq_o        <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (rx_valid_o && rx_ready_i) rx_valid_o <= 1'b0;

      if (start_det) begin
        state   <= ST_SHIFT;
        kind    <= K_FIRST;
        bit_cnt <= '0;
        sda_drv <= 1'b0;
        start_o <= 1'b1;
        stop_o  <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        sda_drv <= 1'b0;
        stop_o  <= 1'b1;
        start_o <= 1'b0;
      end else begin
        unique case (state)
          ST_SHIFT: if (scl_rise) begin
            shreg   <= byte_in;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
              if (m_accept) begin
                rx_data_o    <= byte_in;
                rx_is_addr_o <= (kind != K_DATA);
                rx_valid_o   <= 1'b1;
                next_kind    <= m_upper ? K_LOWER : K_DATA;
                state        <= ST_BYTE_END;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_BYTE_END: if (scl_fall) begin
            held_q <= hold_sel;
            if (hold_sel) begin
              state <= ST_HOLD;
              irq_o <= 1'b1;
            end else begin
              state   <= ST_ACK;
              nack_q  <= ack_value_i;
              sda_drv <= ~ack_value_i;
            end
          end
          ST_HOLD: if (release_i) begin
            state   <= ST_ACK;
            nack_q  <= ack_value_i;
            sda_drv <= ~ack_value_i;
          end
          ST_ACK: if (scl_fall) begin
            sda_drv <= 1'b0;
            bit_cnt <= '0;
            kind    <= next_kind;
            state   <= nack_q ? ST_IDLE : ST_SHIFT;
            if (!held_q) irq_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_drive_low_o = (state == ST_HOLD);
  assign sda_drive_low_o = sda_drv;
  assign ack_time_o      = ((state == ST_HOLD) || (state == ST_ACK)) &&
                           (addr_hold_en_i || data_hold_en_i);
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic scl_drive_low_o,
  input logic sda_drive_low_o,
  input logic release_i,
  input logic rx_valid_o,
  input logic rx_ready_i,
  input logic ack_time_o,
  input logic start_o,
  input logic stop_o,
  input logic irq_o
);
  // R6
  stretch_until_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low_o && !release_i |=> scl_drive_low_o);
  // R7
  stretch_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low_o) |-> irq_o);
  // R8
  stretch_in_ack_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low_o |-> ack_time_o);
  // R13
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low_o) |-> !scl_i);
  // R13
  no_sda_during_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low_o |-> !sda_drive_low_o);
  // R1
  status_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));
  // R11
  rx_valid_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o && !rx_ready_i |=> rx_valid_o);
  // R12
  irq_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
endmodule

bind i2c_hold_slave i2cs_checker chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i),
  .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
  .release_i(release_i), .rx_valid_o(rx_valid_o), .rx_ready_i(rx_ready_i),
  .ack_time_o(ack_time_o), .start_o(start_o), .stop_o(stop_o), .irq_o(irq_o)
);

// File: tb/i2c_hold_slave_tb_top.sv
module i2c_hold_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam logic [9:0] OWN = 10'h2A5;
  localparam logic [7:0] A7B = 8'h4A;  // own[6:0]=0x25, write
  localparam logic [7:0] A10H = 8'hF4; // 11110 10 0
  localparam logic [7:0] A10L = 8'hA5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_line, sda_line;
  logic scl_drv, sda_drv;
  logic addr_hold = 0, data_hold = 0, gcall = 0, ten = 0, ackv = 0, rel = 0, rdy = 0;
  logic [7:0] rx_data;
  logic rx_is_addr, rx_valid, ack_time, start_s, stop_s, irq;
  int errors = 0, checks = 0, irq_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = scl_m & ~scl_drv;
  assign sda_line = sda_m & ~sda_drv;

  i2c_hold_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_drive_low_o(scl_drv), .sda_drive_low_o(sda_drv),
    .addr_hold_en_i(addr_hold), .data_hold_en_i(data_hold),
    .gcall_en_i(gcall), .ten_bit_en_i(ten), .own_addr_i(OWN),
    .ack_value_i(ackv), .release_i(rel),
    .rx_data_o(rx_data), .rx_is_addr_o(rx_is_addr), .rx_valid_o(rx_valid),
    .rx_ready_i(rdy), .ack_time_o(ack_time), .start_o(start_s),
    .stop_o(stop_s), .irq_o(irq)
  );

  always @(posedge clk) if (rst_n && irq) irq_cnt <= irq_cnt + 1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1; tick(HALF); scl_m = 1; wait_scl_high(); tick(HALF);
    sda_m = 0; tick(HALF); scl_m = 0; tick(HALF);
  endtask

  task automatic m_stop();
    sda_m = 0; tick(HALF); scl_m = 1; wait_scl_high(); tick(HALF);
    sda_m = 1; tick(HALF);
  endtask

  task automatic m_bit(input logic b);
    sda_m = b; tick(HALF); scl_m = 1; wait_scl_high(); tick(HALF);
    scl_m = 0; tick(HALF);
  endtask

  task automatic rd();
    rdy = 1; tick(1); rdy = 0;
  endtask

  // ack: 0 = ACK seen; held/at/rv/irq_h sampled after the eighth fall
  task automatic m_byte(input logic [7:0] b, input logic hold_ack,
                        output logic ack, output logic held, output logic at,
                        output logic rv, output int irq_h);
    int c0;
    c0 = irq_cnt;
    for (int i = 7; i >= 0; i--) m_bit(b[i]);
    sda_m = 1;
    held = scl_drv; at = ack_time; rv = rx_valid; irq_h = irq_cnt - c0;
    if (held) begin
      tick(4); ackv = hold_ack; rel = 1; tick(1); rel = 0; tick(HALF);
    end
    scl_m = 1; wait_scl_high(); tick(HALF/2);
    ack = sda_line; tick(HALF/2);
    scl_m = 0; tick(HALF);
  endtask

  task automatic t_reset();
    chk("R13 reset scl drive", scl_drv, 0);
    chk("R13 reset sda drive", sda_drv, 0);
    chk("R1 reset start", start_s, 0);
    chk("R1 reset stop", stop_s, 0);
    chk("R11 reset rx_valid", rx_valid, 0);
    chk("R8 reset ack_time", ack_time, 0);
  endtask

  task automatic t_plain();
    logic ack, held, at, rv; int ih, c0;
    ackv = 0; m_start();
    chk("R1 start set", start_s, 1);
    chk("R1 stop clear", stop_s, 0);
    c0 = irq_cnt;
    m_byte(A7B, 0, ack, held, at, rv, ih);
    chk("R2 7-bit ack", ack, 0);
    chk("R13 no stretch", held, 0);
    chk("R8 no ack_time without hold", at, 0);
    chk("R11 rx_valid at eighth", rv, 1);
    chk("R11 rx_data addr", rx_data, A7B);
    chk("R11 rx_is_addr", rx_is_addr, 1);
    chk("R12 irq after ninth", irq_cnt - c0, 1);
    rd();
    chk("R11 rx_valid cleared by read", rx_valid, 0);
    m_byte(A7B, 0, ack, held, at, rv, ih);
    chk("R5 data equal to addr acked", ack, 0);
    chk("R5 data not address", rx_is_addr, 0);
    m_byte(8'h5A, 0, ack, held, at, rv, ih);
    chk("R11 overwrite keeps valid", rx_valid, 1);
    chk("R11 data value", rx_data, 8'h5A);
    rd(); m_stop();
    chk("R1 stop set", stop_s, 1);
    chk("R1 start clear", start_s, 0);
  endtask

  task automatic t_nack();
    logic ack, held, at, rv; int ih;
    ackv = 1; m_start();
    m_byte(A7B, 1, ack, held, at, rv, ih);
    chk("R3 nack releases sda", ack, 1);
    rd();
    m_byte(8'h33, 1, ack, held, at, rv, ih);
    chk("R3 ignored after nack", rv, 0);
    m_stop(); ackv = 0;
  endtask

  task automatic t_unaddr();
    logic ack, held, at, rv; int ih, c0;
    m_start(); c0 = irq_cnt;
    m_byte(8'h52, 0, ack, held, at, rv, ih);
    chk("R4 other addr no ack", ack, 1);
    chk("R4 other addr no rx", rv, 0);
    m_byte(A7B, 0, ack, held, at, rv, ih);
    chk("R4 later own byte no ack", ack, 1);
    chk("R4 later own byte no rx", rv, 0);
    chk("R4 no irq", irq_cnt - c0, 0);
    m_start();
    m_byte(A7B, 0, ack, held, at, rv, ih);
    chk("R2 repeated start address", ack, 0);
    rd(); m_stop();
  endtask

  task automatic t_addr_hold();
    logic ack, held, at, rv; int ih;
    addr_hold = 1; ackv = 1; m_start();
    m_byte(A7B, 0, ack, held, at, rv, ih);
    chk("R6 stretch with nack preset", held, 1);
    chk("R6 irq at hold", ih, 1);
    chk("R8 ack_time in hold", at, 1);
    chk("R3 ack value taken at release", ack, 0);
    rd();
    m_byte(8'h11, 0, ack, held, at, rv, ih);
    chk("R6 no stretch for data", held, 0);
    chk("R8 ack_time with addr hold on", at, 1);
    rd(); m_stop(); addr_hold = 0; ackv = 0;
  endtask

  task automatic t_data_hold();
    logic ack, held, at, rv; int ih;
    data_hold = 1; m_start();
    m_byte(A7B, 0, ack, held, at, rv, ih);
    chk("R7 address not stretched", held, 0);
    rd(); ackv = 1;
    m_byte(8'h3C, 1, ack, held, at, rv, ih);
    chk("R7 data stretched with nack preset", held, 1);
    chk("R7 irq at hold", ih, 1);
    chk("R11 rbf at hold", rv, 1);
    chk("R7 nack kept", ack, 1);
    chk("R11 held data value", rx_data, 8'h3C);
    rd(); m_stop(); data_hold = 0; ackv = 0;
  endtask

  task automatic t_ten();
    logic ack, held, at, rv; int ih;
    ten = 1; addr_hold = 1; m_start();
    m_byte(A10H, 0, ack, held, at, rv, ih);
    chk("R9 upper byte stretched", held, 1);
    chk("R9 upper byte ack_time", at, 1);
    chk("R9 upper byte ack", ack, 0);
    rd();
    m_byte(A10L, 0, ack, held, at, rv, ih);
    chk("R9 lower byte stretched", held, 1);
    chk("R9 lower byte ack_time", at, 1);
    chk("R9 lower byte ack", ack, 0);
    rd();
    m_byte(8'h77, 0, ack, held, at, rv, ih);
    chk("R9 data after 10-bit", rx_is_addr, 0);
    rd(); m_stop();
    m_start();
    m_byte(A10H, 0, ack, held, at, rv, ih);
    rd();
    m_byte(8'hA6, 0, ack, held, at, rv, ih);
    chk("R9 wrong lower byte nack", ack, 1);
    m_stop(); ten = 0; addr_hold = 0;
  endtask

  task automatic t_gcall();
    logic ack, held, at, rv; int ih;
    gcall = 1; addr_hold = 1; m_start();
    m_byte(8'h00, 0, ack, held, at, rv, ih);
    chk("R10 gcall stretched", held, 1);
    chk("R10 gcall irq", ih, 1);
    chk("R10 gcall ack", ack, 0);
    rd(); m_stop();
    gcall = 0; m_start();
    m_byte(8'h00, 0, ack, held, at, rv, ih);
    chk("R10 gcall off ignored", ack, 1);
    chk("R10 gcall off no stretch", held, 0);
    m_stop(); addr_hold = 0;
  endtask

  initial begin
    tick(5); rst_n = 1; tick(5);
    t_reset();
    t_plain();
    t_nack();
    t_unaddr();
    t_addr_hold();
    t_data_hold();
    t_ten();
    t_gcall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule